// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital mode sequencer of a single-wire bus transceiver. It takes a mode-enable pin, a transmit-data pin, the sampled bus level and an overtemperature flag. From these it drives the regulator-inhibit control, the receive-data pin, the transmitter drive enable and a two-bit mode code. It steps through power-up, standby, normal and sleep. Changes between modes are paced by a delay counter that counts clock ticks, and the enable pin is synchronized through two flops before the sequencer sees it.

In sleep the block watches the bus for a dominant level that lasts the whole wake-up filter time. When that happens it turns the regulator inhibit back on, moves to standby and holds the receive-data pin low as a wake indication. The indication stays until the host raises enable and normal mode is reached. The inhibit control comes on again only through power-up or such a filtered wake-up. A host that keeps its own supply can therefore move from sleep to normal without powering the regulator. All time constants are given in microseconds and converted with a ticks-per-microsecond parameter.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the mode code (0 power-up, 1 standby, 2 normal, 3 sleep) reaches 1 within two clocks, with inh_on=1, rxd_pin=1 and tx_drive=0.
- R2: With en_pin high in standby or sleep, the mode code becomes 2. The change does not happen within SW_CYC clocks of the enable change and has happened by SW_CYC+5 clocks, where SW_CYC = SWITCH_US*TICKS_PER_US.
- R3: With en_pin low in normal, the mode code becomes 3 with the same timing as R2. In sleep, inh_on=0.
- R4: An enable level that reverts before the switch delay runs out cancels the change, and the mode code stays the same.
- R5: In sleep, a bus_rx low level lasting WAKE_CYC consecutive clocks (WAKE_CYC = WAKE_US*TICKS_PER_US) moves the mode to 1, sets inh_on=1 and drives rxd_pin=0.
- R6: In sleep, low bus pulses shorter than WAKE_CYC restart the wake filter, so any number of them causes no wake-up.
- R7: After a wake-up, rxd_pin stays 0 whatever the bus does until normal mode is reached. In normal, rxd_pin equals bus_rx.
- R8: In normal with ot_flag low, tx_drive is the inverse of txd_pin (low txd_pin drives the bus dominant).
- R9: While ot_flag is high, tx_drive is 0 and rxd_pin still follows bus_rx. Drive returns when the flag clears.
- R10: Outside normal, tx_drive is 0 for any txd_pin. Without a pending wake indication, rxd_pin is 1 for any bus_rx.
- R11: inh_on rises only at reset or on a filtered wake-up. Reaching normal from sleep through en_pin leaves inh_on at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | Mode enable, asynchronous, high requests normal |
| txd_pin | input | 1 | Transmit data, low requests dominant |
| bus_rx | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| ot_flag | input | 1 | Overtemperature flag |
| inh_on | output | 1 | Regulator inhibit control, 1 keeps regulator on |
| rxd_pin | output | 1 | Receive data or wake indication |
| tx_drive | output | 1 | Transmitter drive enable, 1 pulls the bus dominant |
| mode_o | output | 2 | Current mode code |

## Verification
The bench targets the filter boundary by sending trains of low pulses just shorter than the filter time. A filter that failed to restart would add the pulses together and wake falsely. A single long pulse must wake the block, and an off-by-a-large-margin filter would miss it. Short enable glitches are applied in sleep to expose a switch counter that does not abort, since that design would fall into normal mode. After a wake, the bench toggles the bus in standby. A flag that is cleared too early would let rxd_pin rise. The bench also goes from sleep to normal by enable alone, to catch an inhibit output wrongly derived from the mode.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [1:0] {
        MODE_PWRUP = 2'd0,
        MODE_STBY  = 2'd1,
        MODE_NORM  = 2'd2,
        MODE_SLEEP = 2'd3
    } mode_e;

    typedef struct packed {
        logic inh;
        logic rxd;
        logic drive;
    } pin_out_t;

    // Mode the enable level asks for from the current mode.
    function automatic mode_e target_mode(mode_e cur, logic en);
        mode_e t;
        case (cur)
            MODE_PWRUP: t = MODE_STBY;
            MODE_STBY:  t = en ? MODE_NORM : MODE_STBY;
            MODE_SLEEP: t = en ? MODE_NORM : MODE_SLEEP;
            default:    t = en ? MODE_NORM : MODE_SLEEP;
        endcase
        return t;
    endfunction

    function automatic int us_to_cyc(int us, int ticks);
        return (us * ticks < 1) ? 1 : us * ticks;
    endfunction

endpackage

// File: rtl/lin_en_sync.sv
module lin_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
    parameter int WAKE_CYC = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic bus_rx,
    output logic wake_p
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

    logic [CW-1:0] low_cnt;

    always_comb wake_p = armed && !bus_rx && (low_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !armed || bus_rx) low_cnt <= '0;
        else if (!wake_p)            low_cnt <= low_cnt + 1'b1;
    end

    // R6: the filter count never runs past the filter length
    a_r6_filter_bound: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= LAST);

    // R6: a recessive sample restarts the filter
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        bus_rx |=> (low_cnt == '0));
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
    import lin_mode_pkg::*;
#(
    parameter int SW_CYC = 40
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en_s,
    input  logic  wake_p,
    output mode_e mode,
    output logic  inh,
    output logic  wake_flag
);
    localparam int SW = $clog2(SW_CYC + 1);
    localparam logic [SW-1:0] SW_LAST = SW'(SW_CYC - 1);

    mode_e         tgt;
    logic          pend;
    logic [SW-1:0] sw_cnt;
    logic          do_wake;

    always_comb begin
        tgt     = target_mode(mode, en_s);
        do_wake = wake_p && (mode == MODE_SLEEP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_PWRUP;
            inh       <= 1'b1;
            wake_flag <= 1'b0;
            pend      <= 1'b0;
            sw_cnt    <= '0;
        end else if (do_wake) begin
            mode      <= MODE_STBY;
            inh       <= 1'b1;
            wake_flag <= 1'b1;
            pend      <= 1'b0;
            sw_cnt    <= '0;
        end else if (mode == MODE_PWRUP) begin
            mode <= MODE_STBY;
        end else if (tgt != mode) begin
            if (!pend) begin
                pend   <= 1'b1;
                sw_cnt <= '0;
            end else if (sw_cnt == SW_LAST) begin
                mode   <= tgt;
                pend   <= 1'b0;
                sw_cnt <= '0;
                if (tgt == MODE_NORM)  wake_flag <= 1'b0;
                if (tgt == MODE_SLEEP) inh       <= 1'b0;
            end else begin
                sw_cnt <= sw_cnt + 1'b1;
            end
        end else begin
            pend   <= 1'b0;
            sw_cnt <= '0;
        end
    end

    a_r2_timer_bound: assert property (@(posedge clk) disable iff (rst)
        sw_cnt <= SW_LAST);

    // R4: without a running switch request the mode holds
    a_r4_no_unpaced_change: assert property (@(posedge clk) disable iff (rst)
        (!pend && !do_wake && mode != MODE_PWRUP) |=> $stable(mode));

    a_r3_sleep_inh_off: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SLEEP) |-> !inh);

    a_r5_wake_to_stby: assert property (@(posedge clk) disable iff (rst)
        do_wake |=> (mode == MODE_STBY && inh && wake_flag));

    a_r7_norm_clears_flag: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORM) |-> !wake_flag);

    a_r11_inh_rise_by_wake: assert property (@(posedge clk) disable iff (rst)
        $rose(inh) |-> ($past(mode) == MODE_SLEEP && $past(wake_p)));
endmodule

// File: rtl/lin_pin_stage.sv
module lin_pin_stage
    import lin_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mode_e    mode,
    input  logic     inh,
    input  logic     wake_flag,
    input  logic     txd_pin,
    input  logic     bus_rx,
    input  logic     ot_flag,
    output pin_out_t pins
);
    logic in_norm;

    always_comb begin
        in_norm    = (mode == MODE_NORM);
        pins.inh   = inh;
        pins.rxd   = in_norm ? bus_rx : !wake_flag;
        pins.drive = in_norm && !txd_pin && !ot_flag;
    end

    a_r10_no_drive_outside_norm: assert property (@(posedge clk) disable iff (rst)
        !in_norm |-> !pins.drive);

    a_r9_ot_blocks_drive: assert property (@(posedge clk) disable iff (rst)
        ot_flag |-> !pins.drive);

    a_r7_flag_holds_rxd: assert property (@(posedge clk) disable iff (rst)
        (wake_flag && !in_norm) |-> !pins.rxd);
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int TICKS_PER_US = 4,
    parameter int WAKE_US      = 150,
    parameter int SWITCH_US    = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_pin,
    input  logic       txd_pin,
    input  logic       bus_rx,
    input  logic       ot_flag,
    output logic       inh_on,
    output logic       rxd_pin,
    output logic       tx_drive,
    output logic [1:0] mode_o
);
    localparam int WAKE_CYC = us_to_cyc(WAKE_US, TICKS_PER_US);
    localparam int SW_CYC   = us_to_cyc(SWITCH_US, TICKS_PER_US);

    logic     en_s;
    logic     wake_p;
    logic     inh;
    logic     wake_flag;
    mode_e    mode;
    pin_out_t pins;

    lin_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(en_pin), .d_sync(en_s)
    );

    lin_wake_filter #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk(clk), .rst(rst), .armed(mode == MODE_SLEEP),
        .bus_rx(bus_rx), .wake_p(wake_p)
    );

    lin_mode_fsm #(.SW_CYC(SW_CYC)) u_fsm (
        .clk(clk), .rst(rst), .en_s(en_s), .wake_p(wake_p),
        .mode(mode), .inh(inh), .wake_flag(wake_flag)
    );

    lin_pin_stage u_pins (
        .clk(clk), .rst(rst), .mode(mode), .inh(inh), .wake_flag(wake_flag),
        .txd_pin(txd_pin), .bus_rx(bus_rx), .ot_flag(ot_flag), .pins(pins)
    );

    assign inh_on   = pins.inh;
    assign rxd_pin  = pins.rxd;
    assign tx_drive = pins.drive;
    assign mode_o   = mode;
endmodule

// File: tb/lin_mode_ctrl_tb.sv
module lin_mode_ctrl_tb;
    localparam int TPU  = 4;
    localparam int WUS  = 150;
    localparam int SUS  = 10;
    localparam int WAKE = WUS * TPU;
    localparam int SW   = SUS * TPU;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_pin = 1'b0, txd_pin = 1'b1, bus_rx = 1'b1, ot_flag = 1'b0;
    logic inh_on, rxd_pin, tx_drive;
    logic [1:0] mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lin_mode_ctrl #(.TICKS_PER_US(TPU), .WAKE_US(WUS), .SWITCH_US(SUS)) u_dut (
        .clk(clk), .rst(rst), .en_pin(en_pin), .txd_pin(txd_pin), .bus_rx(bus_rx),
        .ot_flag(ot_flag), .inh_on(inh_on), .rxd_pin(rxd_pin), .tx_drive(tx_drive),
        .mode_o(mode_o)
    );

    function automatic logic exp_drive(logic txd, logic ot);
        return !txd && !ot;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        rst = 1'b0;
        tick(3);
        chk("R1 mode", mode_o, 1); chk("R1 inh", inh_on, 1);
        chk("R1 rxd", rxd_pin, 1); chk("R1 drive", tx_drive, 0);

        // R2 standby -> normal
        en_pin = 1'b1;
        tick(SW);     chk("R2 early", int'(mode_o == 2), 0);
        tick(5);      chk("R2 mode", mode_o, 2);

        // R8 / R9 random traffic in normal
        for (int i = 0; i < 300; i++) begin
            txd_pin = 1'($urandom);
            bus_rx  = 1'($urandom);
            ot_flag = ($urandom % 4) == 0;
            tick(1);
            chk(ot_flag ? "R9 drive" : "R8 drive", tx_drive, exp_drive(txd_pin, ot_flag));
            chk("R9 rxd follows bus", rxd_pin, bus_rx);
        end
        ot_flag = 1'b1; txd_pin = 1'b0; tick(1);
        chk("R9 ot forces off", tx_drive, 0);
        ot_flag = 1'b0; tick(1);
        chk("R9 restored", tx_drive, 1);
        txd_pin = 1'b1; bus_rx = 1'b1;

        // R3 normal -> sleep
        en_pin = 1'b0;
        tick(SW);     chk("R3 early", mode_o, 2);
        tick(5);      chk("R3 mode", mode_o, 3); chk("R3 inh", inh_on, 0);
        txd_pin = 1'b0; bus_rx = 1'b0; tick(3);
        chk("R10 drive in sleep", tx_drive, 0); chk("R10 rxd in sleep", rxd_pin, 1);
        txd_pin = 1'b1; bus_rx = 1'b1; tick(1);

        // R4 enable glitch
        en_pin = 1'b1; tick(5); en_pin = 1'b0;
        tick(SW + 10); chk("R4 glitch ignored", mode_o, 3);

        // R6 short pulses
        for (int p = 0; p < 8; p++) begin
            bus_rx = 1'b0; tick(WAKE - 20 + int'($urandom % 10));
            bus_rx = 1'b1; tick(3);
        end
        chk("R6 no wake mode", mode_o, 3); chk("R6 inh", inh_on, 0); chk("R6 rxd", rxd_pin, 1);

        // R5 long pulse wakes
        bus_rx = 1'b0; tick(WAKE + 5);
        chk("R5 mode", mode_o, 1); chk("R5 inh", inh_on, 1); chk("R5 rxd", rxd_pin, 0);
        bus_rx = 1'b1; txd_pin = 1'b0; tick(4);
        chk("R7 flag holds", rxd_pin, 0); chk("R10 drive in standby", tx_drive, 0);
        txd_pin = 1'b1;

        // R7 normal clears flag
        en_pin = 1'b1; tick(SW + 6);
        chk("R7 mode", mode_o, 2);
        bus_rx = 1'b1; tick(1); chk("R7 rxd rec", rxd_pin, 1);
        bus_rx = 1'b0; tick(1); chk("R7 rxd dom", rxd_pin, 0);
        bus_rx = 1'b1;

        // R11 sleep -> normal via enable keeps inhibit off
        en_pin = 1'b0; tick(SW + 6); chk("R11 sleep", mode_o, 3);
        en_pin = 1'b1; tick(SW + 6);
        chk("R11 mode", mode_o, 2); chk("R11 inh stays off", inh_on, 0);
        bus_rx = 1'b0; tick(1); chk("R11 rxd follows", rxd_pin, 0);
        bus_rx = 1'b1; tick(1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule